// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is the timekeeping core of a real-time clock. It keeps a 32-bit unsigned count of elapsed seconds. The count advances by one on each single-cycle pulse of a one-second tick input, but only while the counter-enable bit is set. A host reaches the core through a byte-wide register port. The port has an enable strobe, a write/read select, an 8-bit address, and a registered read-data bus that returns the addressed byte one cycle after a read strobe.

A new time is loaded in steps. The host first stages the three upper bytes, then writes the least-significant byte. That final write transfers all four bytes into the counter in a single cycle, so the counter never shows a half-written value. The read bytes always show the live count. Because of this, a host that reads the bytes one at a time can see a carry between reads. It can detect this by reading the low byte again and finding a smaller value.

A second set of four bytes holds an alarm time. An alarm becomes pending when a tick moves the count onto the alarm value while alarm compare is enabled. The interrupt output is a level that stays high until the host clears the pending flag by writing one to bit 0 of the status register.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the count, the staged bytes and the alarm bytes are zero, both enable bits and the pending flag are clear, `alarm_irq` is low, and every mapped offset reads zero.
- R2: Offset 0 is the control register. Bit 7 enables counting and bit 1 enables alarm compare. Both bits read back as written, and the other bits always read 0.
- R3: While bit 7 of offset 0 is set, each cycle with `sec_tick` high adds one to the count. While bit 7 is clear, the count holds and ticks are ignored.
- R4: A write to offset 3, 4 or 5 (staged bytes 1 to 3) changes only that staged byte, and the byte reads back at its own offset. The count is not affected.
- R5: A write of value V to offset 2 loads the count with {staged byte 3, staged byte 2, staged byte 1, V} in one cycle. When a tick arrives in the same cycle, the load wins and that tick is dropped.
- R6: Offsets 6 to 9 return the live count, least-significant byte at offset 6. A read strobe at an edge updates `bus_rdata` at that edge, and `bus_rdata` holds its value until the next read.
- R7: An enabled tick at count 0xFFFFFFFF wraps the count to 0.
- R8: Offsets 10 to 13 hold the alarm value, least-significant byte at offset 10. They are writable and read back.
- R9: The pending flag is set only by an enabled tick whose incremented count equals the alarm value while bit 1 of offset 0 is set. A load that reaches the alarm value does not set it, and neither does a tick while alarm compare is off.
- R10: The pending flag drives `alarm_irq`, reads as bit 0 of offset 1, and stays set until a write to offset 1 with bit 0 high clears it. A write to offset 1 with bit 0 low has no effect.
- R11: Offsets 14 and above read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second, synchronous to clk |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_en |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, updated on the edge that takes a read strobe |
| alarm_irq | output | 1 | Level alarm interrupt, high while the alarm is pending |

## Verification
The counter is exercised with ticks while enabled, ticks while disabled, and a tick that coincides with the committing byte-0 write. Together these show whether enable gating and load priority are implemented, or whether ticks simply always count. The staged load is checked with distinct values in every byte and with an all-ones pattern. Distinct bytes expose swapped byte lanes and early commits. The all-ones load is followed by a tick to show the wrap to zero. The alarm is approached three ways: by ticks with compare off, by a load that lands on the alarm value, and by ticks with compare on. Only the last may raise the interrupt, and the clear is tried with a zero and a one in bit 0.

// File: rtl/rtc_pkg.sv
// Package: rtc_pkg
// Shared constants and types for the seconds-counter core.
// Assumes the byte lanes are 8 bits wide and the register map starts at
// a base offset that the top module supplies.
package rtc_pkg;
    localparam int BYTE_W          = 8;
    // register offsets relative to the core's base address
    localparam int OFS_CTRL        = 0;
    localparam int OFS_ALARM_STAT  = 1;
    localparam int OFS_WR_FIRST    = 2;
    // bit positions decoded by the host
    localparam int CTRL_RUN_BIT    = 7;
    localparam int CTRL_ALARM_BIT  = 1;
    localparam int STAT_PEND_BIT   = 0;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;
endpackage

// File: rtl/rtc_bus_regs.sv
// Module: rtc_bus_regs
// Decodes the byte-wide register port. Holds the control bits, the staged
// time bytes and the alarm bytes, and produces the load and clear strobes.
// Read data is registered: it is captured on the edge that takes a read.
// Assumes bus_en is a one-cycle qualifier for each access.
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int                NUM_BYTES = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BYTE_W-1:0]             bus_wdata,
    input  logic [NUM_BYTES*BYTE_W-1:0]   count_i,
    input  logic                          pend_i,
    output logic                          run_en,
    output logic                          alarm_en,
    output logic                          load_stb,
    output logic [NUM_BYTES*BYTE_W-1:0]   load_val,
    output logic [NUM_BYTES*BYTE_W-1:0]   alarm_val,
    output logic                          clr_stb,
    output logic [BYTE_W-1:0]             bus_rdata
);
    localparam int RD_FIRST  = OFS_WR_FIRST + NUM_BYTES;
    localparam int ALM_FIRST = RD_FIRST + NUM_BYTES;
    localparam int MAP_END   = ALM_FIRST + NUM_BYTES;

    logic [ADDR_W-1:0] ofs;
    bus_op_e           op;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              mapped;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] stage_q [NUM_BYTES];
    logic [BYTE_W-1:0] alarm_q [NUM_BYTES];

    // offset within the core's window
    assign ofs = bus_addr - BASE_ADDR;

    // classify the current bus cycle
    always_comb begin
        if (!bus_en)     op = OP_IDLE;
        else if (bus_we) op = OP_WRITE;
        else             op = OP_READ;
    end

    assign wr_ctrl  = (op == OP_WRITE) && (ofs == ADDR_W'(OFS_CTRL));
    assign wr_stat  = (op == OP_WRITE) && (ofs == ADDR_W'(OFS_ALARM_STAT));
    assign load_stb = (op == OP_WRITE) && (ofs == ADDR_W'(OFS_WR_FIRST));
    assign clr_stb  = wr_stat && bus_wdata[STAT_PEND_BIT];
    assign mapped   = (ofs < ADDR_W'(MAP_END));

    // control register: counter enable and alarm compare enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            alarm_en <= 1'b0;
        end else if (wr_ctrl) begin
            run_en   <= bus_wdata[CTRL_RUN_BIT];
            alarm_en <= bus_wdata[CTRL_ALARM_BIT];
        end
    end

    // one staged byte and one alarm byte per lane
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else if ((op == OP_WRITE) && (ofs == ADDR_W'(OFS_WR_FIRST + g)))
                stage_q[g] <= bus_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[g] <= '0;
            else if ((op == OP_WRITE) && (ofs == ADDR_W'(ALM_FIRST + g)))
                alarm_q[g] <= bus_wdata;
        end

        assign alarm_val[g*BYTE_W +: BYTE_W] = alarm_q[g];

        if (g == 0) begin : g_low
            assign load_val[BYTE_W-1:0] = bus_wdata;
        end else begin : g_high
            assign load_val[g*BYTE_W +: BYTE_W] = stage_q[g];
        end
    end

    // read multiplexer; unmapped offsets give zero
    always_comb begin
        rd_next = '0;
        if (ofs == ADDR_W'(OFS_CTRL)) begin
            rd_next[CTRL_RUN_BIT]   = run_en;
            rd_next[CTRL_ALARM_BIT] = alarm_en;
        end
        if (ofs == ADDR_W'(OFS_ALARM_STAT))
            rd_next[STAT_PEND_BIT] = pend_i;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (ofs == ADDR_W'(OFS_WR_FIRST + i)) rd_next = stage_q[i];
            if (ofs == ADDR_W'(RD_FIRST + i))     rd_next = count_i[i*BYTE_W +: BYTE_W];
            if (ofs == ADDR_W'(ALM_FIRST + i))    rd_next = alarm_q[i];
        end
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (op == OP_READ)
            bus_rdata <= rd_next;
    end

    assert_unmapped_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !mapped) |=> (bus_rdata == '0));

    assert_ctrl_takes_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (run_en == $past(bus_wdata[CTRL_RUN_BIT]))
                 && (alarm_en == $past(bus_wdata[CTRL_ALARM_BIT])));

    assert_ctrl_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable({run_en, alarm_en}));

    assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(bus_rdata));
endmodule

// File: rtl/rtc_count_core.sv
// Module: rtc_count_core
// The seconds counter. A load commits a whole new value in one cycle and
// takes priority over a tick; otherwise an enabled tick adds one, wrapping
// at the top of the range. Assumes tick is a one-cycle synchronous pulse.
module rtc_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    // load first, then enabled increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_stb)
            count <= load_val;
        else if (run_en && tick)
            count <= count + CNT_W'(1);
    end

    assert_load_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (count == $past(load_val)));

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_stb) |=> $stable(count));

    assert_tick_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !load_stb) |=> (count == $past(count) + CNT_W'(1)));

    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !load_stb && (count == '1)) |=> (count == '0));
endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: rtc_alarm_unit
// Compares the count a tick is about to produce against the alarm value
// and latches a pending flag, which software clears by a write-one.
// A set in the same cycle as a clear wins. Assumes the count and the
// alarm value come straight from their registers.
module rtc_alarm_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             alarm_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             clr_stb,
    output logic             pend
);
    logic [CNT_W-1:0] next_cnt;
    logic             hit;
    logic             set_cond;

    // value the counter takes on an enabled tick
    assign next_cnt = count + CNT_W'(1);
    assign hit      = (next_cnt == alarm_val);
    assign set_cond = tick && run_en && !load_stb && alarm_en && hit;

    // sticky pending flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set_cond)
            pend <= 1'b1;
        else if (clr_stb)
            pend <= 1'b0;
    end

    assert_set_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick && run_en && alarm_en && !load_stb));

    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_stb) |=> pend);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_cond) |=> !pend);
endmodule

// File: rtl/rtc_seconds_core.sv
// Module: rtc_seconds_core
// Top of the seconds counter with alarm. Joins the register port, the
// counter and the alarm unit. The interrupt is the pending flag register.
// Assumes sec_tick and the bus are synchronous to clk.
module rtc_seconds_core
    import rtc_pkg::*;
#(
    parameter int                NUM_BYTES = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    localparam int CNT_W = NUM_BYTES * BYTE_W;

    logic             run_en;
    logic             alarm_en;
    logic             load_stb;
    logic             clr_stb;
    logic             pend;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] alarm_val;
    logic [CNT_W-1:0] count;

    rtc_bus_regs #(
        .NUM_BYTES (NUM_BYTES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_i   (count),
        .pend_i    (pend),
        .run_en    (run_en),
        .alarm_en  (alarm_en),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .alarm_val (alarm_val),
        .clr_stb   (clr_stb),
        .bus_rdata (bus_rdata)
    );

    rtc_count_core #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .run_en   (run_en),
        .load_stb (load_stb),
        .load_val (load_val),
        .count    (count)
    );

    rtc_alarm_unit #(
        .CNT_W (CNT_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .run_en    (run_en),
        .alarm_en  (alarm_en),
        .load_stb  (load_stb),
        .count     (count),
        .alarm_val (alarm_val),
        .clr_stb   (clr_stb),
        .pend      (pend)
    );

    assign alarm_irq = pend;

    assert_irq_low_after_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !sec_tick) |=> !alarm_irq);
endmodule

// File: tb/rtc_seconds_core_bench.sv
// Bench for rtc_seconds_core: a driver pushes expected read bytes into a
// queue and a monitor compares them with bus_rdata one cycle later.
module rtc_seconds_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      req;
    } rd_item_t;
    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    rtc_seconds_core u_rtc_seconds_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // note each edge that took a read strobe
    always @(posedge clk) rd_seen <= bus_en && !bus_we;

    // monitor: compare read data after the edge that captured it
    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: read offset %0d got %02h expected %02h",
                         it.req, it.addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic check_irq(input logic exp, input string req);
        n_checks++;
        if (alarm_irq !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm_irq got %b expected %b", req, alarm_irq, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tk = 1'b0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = tk;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
        rd_item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.req = req;
        exp_q.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_count(input logic [31:0] e, input string req);
        for (int i = 0; i < 4; i++) rd(8'(6 + i), e[i*8 +: 8], req);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic load(input logic [31:0] v);
        wr(8'd3, v[15:8]); wr(8'd4, v[23:16]); wr(8'd5, v[31:24]); wr(8'd2, v[7:0]);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_irq(1'b0, "R1");
        for (int a = 0; a < 14; a++) rd(8'(a), 8'h00, "R1");
        // R11: unmapped reads
        rd(8'd14, 8'h00, "R11");
        rd(8'hFF, 8'h00, "R11");
        // R2: control bits
        wr(8'd0, 8'h82); rd(8'd0, 8'h82, "R2");
        wr(8'd0, 8'hFF); rd(8'd0, 8'h82, "R2");
        wr(8'd0, 8'h80); rd(8'd0, 8'h80, "R2");
        // R3: enabled ticks count, disabled ticks ignored
        ticks(5); rd_count(32'd5, "R3");
        wr(8'd0, 8'h00); ticks(3); rd_count(32'd5, "R3");
        // R4: staging bytes only
        wr(8'd3, 8'h12); wr(8'd4, 8'h34); wr(8'd5, 8'h56);
        rd_count(32'd5, "R4");
        rd(8'd3, 8'h12, "R4"); rd(8'd4, 8'h34, "R4"); rd(8'd5, 8'h56, "R4");
        // R5 and R6: commit on byte 0, little-endian live read
        wr(8'd2, 8'h78); rd_count(32'h56341278, "R5");
        rd(8'd2, 8'h78, "R6");
        wr(8'd0, 8'h80); ticks(1); rd(8'd6, 8'h79, "R6");
        // R5: load beats a same-cycle tick
        wr(8'd3, 8'h00); wr(8'd4, 8'h00); wr(8'd5, 8'h00);
        wr(8'd2, 8'h40, 1'b1); rd_count(32'h40, "R5");
        // R7: wrap
        load(32'hFFFFFFFF); rd_count(32'hFFFFFFFF, "R7");
        ticks(1); rd_count(32'h0, "R7");
        // R8: alarm bytes
        wr(8'd10, 8'h05); wr(8'd11, 8'h00); wr(8'd12, 8'h00); wr(8'd13, 8'h00);
        rd(8'd10, 8'h05, "R8"); rd(8'd11, 8'h00, "R8");
        wr(8'd11, 8'hA5); rd(8'd11, 8'hA5, "R8"); wr(8'd11, 8'h00);
        // R9: compare off -> no alarm
        ticks(6); check_irq(1'b0, "R9"); rd_count(32'd6, "R9");
        // R9: load landing on alarm value does not set
        wr(8'd0, 8'h82); load(32'd5); check_irq(1'b0, "R9");
        rd(8'd1, 8'h00, "R9");
        // R9: tick onto alarm sets
        load(32'd0); ticks(4); check_irq(1'b0, "R9");
        ticks(1); check_irq(1'b1, "R9");
        // R10: sticky, status bit, clear
        rd(8'd1, 8'h01, "R10");
        ticks(2); check_irq(1'b1, "R10");
        wr(8'd1, 8'hFE); check_irq(1'b1, "R10");
        wr(8'd1, 8'h01); check_irq(1'b0, "R10");
        rd(8'd1, 8'h00, "R10");
        // R11: unmapped writes change nothing
        wr(8'd0, 8'h00);
        wr(8'd14, 8'hFF); wr(8'd200, 8'h01);
        rd(8'd0, 8'h00, "R11"); rd_count(32'd7, "R11");
        rd(8'd10, 8'h05, "R11"); check_irq(1'b0, "R11");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule